// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for a four-beat burst access to a synchronous memory. A burst begins when either of two active-low address strobes is low at a rising clock edge. The block then captures the whole external address. The two lowest bits of that address become the starting offset of the burst. The upper bits are held unchanged until the next load.

After a load, each clock edge with the active-low advance input low moves the burst one beat forward. The two-bit offset presented on the output follows one of two sequences, chosen by a static order input:
- In linear order the offset counts upward and wraps modulo four.
- In interleaved order the offset is the starting offset XOR the beat number.

The block also drives the beat number. Loading can be repeated on every cycle, so the counter is not needed for back-to-back single accesses. A read whose data is not driven out still advances the counter like any other read. For this reason the block looks only at the advance input and has no read or output-enable qualifier.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `burst_addr` is all zeros and `beat_idx` is 0.
- R2: At a rising edge where `strb_proc_n` or `strb_ctrl_n` is low, the block loads `ext_addr`. From the next cycle `burst_addr` equals that address and `beat_idx` is 0. Each strobe alone is enough to load.
- R3: At an edge with no strobe low, the bits of `burst_addr` above bit 1 do not change.
- R4: At an edge with no strobe low, `beat_idx` goes up by one when `adv_n` is low and stays unchanged when `adv_n` is high.
- R5: When `order_lin_n` is 0 (linear), `burst_addr[1:0]` equals (preset + `beat_idx`) mod 4.
- R6: When `order_lin_n` is 1 (interleaved), `burst_addr[1:0]` equals preset XOR `beat_idx`.
- R7: When a strobe and a low `adv_n` arrive at the same edge, the load wins: `beat_idx` becomes 0 and the new address is presented.
- R8: After beat 3, one more advance returns `beat_idx` to 0 and the offset to the preset. The sequence keeps repeating for as long as advance stays asserted.
- R9: A strobe on every consecutive cycle presents each newly loaded address on the following cycle, with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strb_proc_n | input | 1 | Processor-side address strobe, active low |
| strb_ctrl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance enable, active low |
| ext_addr | input | AW | External word address; bits [1:0] are the preset |
| order_lin_n | input | 1 | 0 selects linear order, 1 selects interleaved order |
| burst_addr | output | AW | Current burst word address |
| beat_idx | output | 2 | Beat number within the burst, 0 to 3 |

## Verification
Two functions can fall in the same cycle: a new load from a strobe and a counter advance. The bench drives both at one edge in directed cases and at random: one strobe, both strobes together, and a strobe combined with a low advance. It passes only if the beat number returns to 0 and the newly captured address appears, with no step applied from the old burst. A bench function restates both ordering formulas independently, and the bench compares the output against it on every cycle.

// File: rtl/burst_pkg.sv
package burst_pkg;

  localparam int unsigned BEAT_W = 2;
  typedef logic [BEAT_W-1:0] beat_t;

  // offset of a given beat relative to the loaded preset
  function automatic beat_t burst_offset(input beat_t preset, input beat_t beat,
                                         input logic linear);
    beat_t r;
    if (linear) r = preset + beat;
    else        r = preset ^ beat;
    return r;
  endfunction

  function automatic beat_t beat_step(input beat_t beat);
    return beat + beat_t'(1);
  endfunction

endpackage

// File: rtl/burst_load_ctrl.sv
module burst_load_ctrl (
  input  logic strb_proc_n,
  input  logic strb_ctrl_n,
  input  logic adv_n,
  output logic load,
  output logic step
);
  // a strobe overrides advance in the same cycle
  always_comb begin
    load = ~strb_proc_n | ~strb_ctrl_n;
    step = ~adv_n & ~load;
  end
endmodule

// File: rtl/burst_seq_counter.sv
module burst_seq_counter
  import burst_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  logic  step,
  output beat_t beat
);
  always_ff @(posedge clk) begin
    if (!rst_n)    beat <= '0;
    else if (load) beat <= '0;
    else if (step) beat <= beat_step(beat);
  end

  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> beat == '0); // R7
  AST_STEP_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && step) |=> beat == beat_t'($past(beat) + 2'd1)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(beat)); // R4
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
  parameter int unsigned AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] ext_addr,
  output logic [AW-1:0] base
);
  always_ff @(posedge clk) begin
    if (!rst_n)    base <= '0;
    else if (load) base <= ext_addr;
  end

  AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(base)); // R3
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int unsigned AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strb_proc_n,
  input  logic          strb_ctrl_n,
  input  logic          adv_n,
  input  logic [AW-1:0] ext_addr,
  input  logic          order_lin_n,
  output logic [AW-1:0] burst_addr,
  output logic [1:0]    beat_idx
);
  localparam int unsigned HI_W = AW - BEAT_W;

  logic          load_ev;
  logic          step_ev;
  beat_t         beat_q;
  logic [AW-1:0] base_q;
  beat_t         offset;

  burst_load_ctrl u_ctrl (
    .strb_proc_n (strb_proc_n),
    .strb_ctrl_n (strb_ctrl_n),
    .adv_n       (adv_n),
    .load        (load_ev),
    .step        (step_ev)
  );

  burst_seq_counter u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load_ev),
    .step  (step_ev),
    .beat  (beat_q)
  );

  burst_base_reg #(.AW(AW)) u_base (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_ev),
    .ext_addr (ext_addr),
    .base     (base_q)
  );

  always_comb begin
    offset     = burst_offset(base_q[BEAT_W-1:0], beat_q, ~order_lin_n);
    burst_addr = {base_q[AW-1:BEAT_W], offset};
    beat_idx   = beat_q;
  end

  AST_LOAD_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> burst_addr == $past(ext_addr)); // R2
  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    !load_ev |=> burst_addr[AW-1:BEAT_W] == $past(burst_addr[AW-1:BEAT_W])); // R3
  AST_BEAT0_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_q == '0) |-> burst_addr == base_q); // R8

  initial assert (HI_W >= 1);
endmodule

// File: tb/sim_burst_addr_gen.sv
module sim_burst_addr_gen;
  localparam int AW = 20;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          strb_proc_n = 1, strb_ctrl_n = 1, adv_n = 1, order_lin_n = 1;
  logic [AW-1:0] ext_addr = '0;
  logic [AW-1:0] burst_addr;
  logic [1:0]    beat_idx;

  int checks = 0, failures = 0;
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_beat = '0;

  always #10 clk = ~clk;

  burst_addr_gen #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .strb_proc_n(strb_proc_n), .strb_ctrl_n(strb_ctrl_n),
    .adv_n(adv_n), .ext_addr(ext_addr), .order_lin_n(order_lin_n),
    .burst_addr(burst_addr), .beat_idx(beat_idx)
  );

  function automatic logic [AW-1:0] expect_addr(logic [AW-1:0] b, logic [1:0] n, logic lin_n);
    logic [1:0] lo;
    if (lin_n == 1'b0) lo = 2'((int'(b[1:0]) + int'(n)) % 4);
    else               lo = {b[1] ^ n[1], b[0] ^ n[0]};
    return {b[AW-1:2], lo};
  endfunction

  task automatic check(string tag, logic [AW-1:0] ea, logic [1:0] eb);
    checks++;
    if (burst_addr !== ea || beat_idx !== eb) begin
      failures++;
      $display("FAIL %s addr=%h beat=%0d expected addr=%h beat=%0d",
               tag, burst_addr, beat_idx, ea, eb);
    end
  endtask

  // drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(logic ps, logic cs, logic av, logic [AW-1:0] a, string force_tag = "");
    string tag;
    logic [AW-1:0] prev_hi;
    strb_proc_n = ps; strb_ctrl_n = cs; adv_n = av; ext_addr = a;
    prev_hi = m_base;
    @(posedge clk);
    if (!ps || !cs) begin
      tag = (!av) ? "R7" : "R2";
      m_base = a; m_beat = 2'd0;
    end else if (!av) begin
      tag = (m_beat == 2'd3) ? "R8" : (order_lin_n ? "R6" : "R5");
      m_beat = m_beat + 2'd1;
    end else tag = "R4";
    if (force_tag != "") tag = force_tag;
    @(negedge clk);
    check(tag, expect_addr(m_base, m_beat, order_lin_n), m_beat);
    if (ps && cs) begin
      checks++;
      if (burst_addr[AW-1:2] !== prev_hi[AW-1:2]) begin
        failures++;
        $display("FAIL R3 upper=%h expected=%h", burst_addr[AW-1:2], prev_hi[AW-1:2]);
      end
    end
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    @(negedge clk);
    check("R1", '0, 2'd0);
    @(negedge clk);
    rst_n = 1;
    @(posedge clk);
    @(negedge clk);
    check("R1", '0, 2'd0);

    // all presets in both orders, beyond one wrap
    for (int o = 0; o < 2; o++) begin
      order_lin_n = o[0];
      for (int p = 0; p < 4; p++) begin
        cyc(p[0], ~p[0], 1'b1, {18'h2A5C3, p[1:0]});
        for (int k = 0; k < 6; k++) cyc(1, 1, 0, '0);
        cyc(1, 1, 1, '0);
      end
    end
    // strobe together with advance; both strobes together
    order_lin_n = 0;
    cyc(1, 0, 1, 20'h00013);
    cyc(1, 1, 0, '0);
    cyc(0, 1, 0, 20'hFFFF2, "R7");
    cyc(0, 0, 0, 20'h12341, "R7");
    // back-to-back single loads
    for (int k = 0; k < 8; k++) cyc(k[0], ~k[0], 1'b1, 20'(k * 37 + 5), "R9");

    // constrained random
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[15:10] == 0) order_lin_n = r[16];
      cyc(r[3:0] != 0 || r[4], r[3:0] != 1 || r[5], r[6] & r[7], 20'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule